// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-wide SPI master that sits behind a tiny three-register window on a microcontroller's internal bus. Software sets the clock mode, the bit rate and the enables in a control register. A transfer starts when software writes the data register. One byte leaves on MOSI, most significant bit first. In the same transfer one byte arrives on MISO. SCK comes from a divider of the system clock. The byte that arrives is kept in a read buffer, which software reads back through the same data address.

A status register reports three events. The first is the end of a transfer. The second is a data write that collided with a transfer still running. The third is a mode fault, raised when another device pulls the select input low. The sticky flags are cleared by a two-step software sequence. A select-disable bit stops the block from watching the select input and drives an output that hands that pin back to general-purpose use.

Register addresses on `reg_addr`: 0 = control, 1 = status, 2 = data. Reads are combinational from `reg_addr`. The side effects of a read happen only when `reg_rd` is high.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the control, status and data registers read 0x00, and `sck_o`, `mosi_o` and `ss_release_o` are low.
- R2: Control bits are: bit 6 enable, bit 5 select-disable, bit 4 master, bit 3 clock polarity, bit 2 clock phase, and the rate code is {bit 7, bit 1, bit 0}. A data write with enable and master set and no transfer running produces exactly 8 SCK pulses. Between transfers SCK rests at the polarity bit.
- R3: Each transfer sends the written byte MSB first and stores the byte received on MISO into the read buffer, in all four clock modes. With phase 0, MOSI is valid before the first SCK edge and MISO is sampled on the leading edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R4: A read of the data register returns the read buffer. The buffer changes only when a transfer completes, so during a transfer it still holds the previous byte.
- R5: Each SCK half-period lasts 2^code system clocks for rate codes 0 to 6. Code 7 behaves like code 6, which is 64 clocks.
- R6: A data write while a transfer runs sets status bit 6 (collision) and leaves the running transfer and its result unchanged.
- R7: Status bit 7 (done) and bit 6 (collision) stay set until software reads the status register and then reads or writes the data register. A data access without that status read first leaves them set.
- R8: With enable and master set and select-disable clear, a low level on `ss_n_i` sets status bit 4 (fault), clears control bit 4 and aborts any running transfer: SCK returns to idle and done is not set.
- R9: With select-disable set, `ss_release_o` is high and a low `ss_n_i` causes no fault and does not disturb a transfer.
- R10: Clearing the enable bit during a transfer returns SCK to idle, sets no done flag and leaves the read buffer unchanged. The next transfer after re-enabling runs all 8 bits correctly.
- R11: The fault flag clears only after a status read followed by a control write.
- R12: A data write while enable or master is clear causes no SCK activity and sets no done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Select input watched for mode faults |
| ss_release_o | output | 1 | High when the select pin is released to general use |

## Verification
The hardest case to reach from the ports is a mode fault or a disable that lands in the middle of a byte. In that case SCK must drop back to idle without a done flag, and the buffer must keep the earlier byte. The bench starts a slow transfer at a half-period of eight clocks. It then pulls the select input low, or writes the control register with enable clear, a fixed number of cycles into the shift. It checks the status, the control readback, SCK and the buffer. A behavioural slave then runs a complete byte, which shows the bit counter was cleared. Collisions are produced the same way, by writing data while a slow transfer is still running.

// File: rtl/spi_mr_pkg.sv
package spi_mr_pkg;
   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_DATA = 2'd2
   } reg_sel_e;

   localparam int CTL_RATE_HI = 7;
   localparam int CTL_EN      = 6;
   localparam int CTL_SSOFF   = 5;
   localparam int CTL_MST     = 4;
   localparam int CTL_CPOL    = 3;
   localparam int CTL_CPHA    = 2;

   localparam int ST_DONE  = 7;
   localparam int ST_COLL  = 6;
   localparam int ST_FAULT = 4;

   typedef struct packed {
      logic       en;
      logic       ssoff;
      logic       master;
      logic       cpol;
      logic       cpha;
      logic [2:0] rate;
   } cfg_t;
endpackage

// File: rtl/spi_mr_sync.sv
module spi_mr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("spi_mr_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= STAGES'({chain, d});
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_mr_rate.sv
module spi_mr_rate #(
   parameter int RATE_W   = 3,
   parameter int CAP_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] code,
   output logic              tick
);
   localparam int CNT_W = (CAP_LOG2 > 0) ? CAP_LOG2 : 1;

   generate
      if (RATE_W < 1) begin : g_bad_rate
         $error("spi_mr_rate: RATE_W must be at least 1");
      end
      if (CAP_LOG2 > (1 << RATE_W) - 1) begin : g_bad_cap
         $error("spi_mr_rate: CAP_LOG2 exceeds the largest rate code");
      end

      if (CAP_LOG2 == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [RATE_W-1:0] eff;
         logic [CNT_W:0]    limit;
         logic [CNT_W-1:0]  cnt;

         always_comb begin
            eff   = (code > RATE_W'(CAP_LOG2)) ? RATE_W'(CAP_LOG2) : code;
            limit = ((CNT_W+1)'(1) << eff) - (CNT_W+1)'(1);
         end

         assign tick = run && ({1'b0, cnt} == limit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (!run)     cnt <= '0;
            else if (tick)     cnt <= '0;
            else               cnt <= cnt + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/spi_mr_shift.sv
module spi_mr_shift #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_data,
   input  logic               abort,
   input  logic               tick,
   input  logic               cpol,
   input  logic               cpha,
   input  logic               miso,
   output logic               busy,
   output logic               sck,
   output logic               mosi,
   output logic               done,
   output logic [FRAME_W-1:0] rx_data
);
   localparam int LAST = 2 * FRAME_W - 1;
   localparam int EW   = $clog2(2 * FRAME_W);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("spi_mr_shift: FRAME_W must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] shreg;
   logic [EW-1:0]      edge_cnt;
   logic               sck_q;
   logic               mosi_q;
   logic               cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         edge_cnt <= '0;
         sck_q    <= 1'b0;
         mosi_q   <= 1'b0;
         shreg    <= '0;
         cap      <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy     <= 1'b0;
            edge_cnt <= '0;
         end else if (busy) begin
            if (tick) begin
               sck_q    <= ~sck_q;
               edge_cnt <= edge_cnt + EW'(1);
               if (!edge_cnt[0]) begin
                  // leading edge
                  if (!cpha) begin
                     cap <= miso;
                  end else begin
                     mosi_q <= shreg[FRAME_W-1];
                     shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                  end
               end else begin
                  // trailing edge
                  if (!cpha) begin
                     shreg  <= {shreg[FRAME_W-2:0], cap};
                     mosi_q <= shreg[FRAME_W-2];
                  end else begin
                     shreg[0] <= miso;
                  end
               end
               if (edge_cnt == EW'(LAST)) begin
                  busy     <= 1'b0;
                  done     <= 1'b1;
                  edge_cnt <= '0;
               end
            end
         end else begin
            if (load) shreg <= load_data;
            if (start) begin
               busy     <= 1'b1;
               sck_q    <= cpol;
               edge_cnt <= '0;
               if (!cpha) mosi_q <= load_data[FRAME_W-1];
            end
         end
      end
   end

   assign sck     = busy ? sck_q : cpol;
   assign mosi    = mosi_q;
   assign rx_data = shreg;

   // R2
   sck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && tick && !abort |=> sck != $past(sck))
      else $error("sck did not toggle on a rate tick");

   // R10
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy && !done)
      else $error("abort did not stop the transfer");
endmodule

// File: rtl/spi_mr_regs.sv
module spi_mr_regs
   import spi_mr_pkg::*;
#(
   parameter int FRAME_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [1:0]         addr,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   input  logic               sel_n,
   input  logic               busy,
   input  logic               done,
   input  logic [FRAME_W-1:0] rx_data,
   output cfg_t               cfg,
   output logic               start,
   output logic               load,
   output logic [FRAME_W-1:0] load_data,
   output logic               abort,
   output logic               release_o
);
   logic [REG_W-1:0]   ctrl;
   logic [FRAME_W-1:0] buffer;
   logic               spif, wcol, modf, arm;
   logic               sel_s;
   logic               wr_data, acc_data, wr_ctl, rd_stat;
   logic               fault_evt, collide, clr_dat, clr_flt;

   spi_mr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sel_n),
      .q     (sel_s)
   );

   always_comb begin
      cfg.en     = ctrl[CTL_EN];
      cfg.ssoff  = ctrl[CTL_SSOFF];
      cfg.master = ctrl[CTL_MST];
      cfg.cpol   = ctrl[CTL_CPOL];
      cfg.cpha   = ctrl[CTL_CPHA];
      cfg.rate   = {ctrl[CTL_RATE_HI], ctrl[1:0]};
   end

   assign wr_data   = wr && (addr == ADDR_DATA);
   assign acc_data  = (wr || rd) && (addr == ADDR_DATA);
   assign wr_ctl    = wr && (addr == ADDR_CTRL);
   assign rd_stat   = rd && (addr == ADDR_STAT);
   assign fault_evt = cfg.en && cfg.master && !cfg.ssoff && !sel_s;
   assign collide   = wr_data && busy;
   assign clr_dat   = acc_data && arm;
   assign clr_flt   = wr_ctl && arm;

   assign load      = wr_data && !busy;
   assign load_data = wdata[FRAME_W-1:0];
   assign start     = wr_data && !busy && cfg.en && cfg.master && !fault_evt;
   assign abort     = busy && (!cfg.en || fault_evt);
   assign release_o = cfg.ssoff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_ctl)    ctrl <= wdata;
         if (fault_evt) ctrl[CTL_MST] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spif   <= 1'b0;
         wcol   <= 1'b0;
         modf   <= 1'b0;
         arm    <= 1'b0;
         buffer <= '0;
      end else begin
         spif <= done || (spif && !clr_dat);
         wcol <= collide || (wcol && !clr_dat);
         modf <= fault_evt || (modf && !clr_flt);
         if (rd_stat && (spif || wcol || modf)) arm <= 1'b1;
         else if (acc_data || wr_ctl)          arm <= 1'b0;
         if (done) buffer <= rx_data;
      end
   end

   always_comb begin
      unique case (addr)
         ADDR_CTRL: rdata = ctrl;
         ADDR_STAT: begin
            rdata           = '0;
            rdata[ST_DONE]  = spif;
            rdata[ST_COLL]  = wcol;
            rdata[ST_FAULT] = modf;
         end
         ADDR_DATA: rdata = REG_W'(buffer);
         default:   rdata = '0;
      endcase
   end

   // R6
   collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data && busy |=> wcol)
      else $error("collision flag not raised");

   // R8
   fault_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> modf && !ctrl[CTL_MST])
      else $error("fault did not set flag and drop master");

   // R4
   buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(buffer))
      else $error("read buffer changed outside transfer end");
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
   import spi_mr_pkg::*;
#(
   parameter int FRAME_W       = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int RATE_CAP_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sck_o,
   output logic             mosi_o,
   input  logic             miso_i,
   input  logic             ss_n_i,
   output logic             ss_release_o
);
   generate
      if (FRAME_W < 2 || FRAME_W > REG_W) begin : g_bad_frame
         $error("spi_regmaster: FRAME_W must lie between 2 and the register width");
      end
   endgenerate

   cfg_t               cfg;
   logic               start, load, abort, busy, done, tick;
   logic [FRAME_W-1:0] load_data, rx_data;

   spi_mr_regs #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .rd        (reg_rd),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .sel_n     (ss_n_i),
      .busy      (busy),
      .done      (done),
      .rx_data   (rx_data),
      .cfg       (cfg),
      .start     (start),
      .load      (load),
      .load_data (load_data),
      .abort     (abort),
      .release_o (ss_release_o)
   );

   spi_mr_rate #(.RATE_W(3), .CAP_LOG2(RATE_CAP_LOG2)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .code  (cfg.rate),
      .tick  (tick)
   );

   spi_mr_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .load      (load),
      .load_data (load_data),
      .abort     (abort),
      .tick      (tick),
      .cpol      (cfg.cpol),
      .cpha      (cfg.cpha),
      .miso      (miso_i),
      .busy      (busy),
      .sck       (sck_o),
      .mosi      (mosi_o),
      .done      (done),
      .rx_data   (rx_data)
   );
endmodule

// File: tb/spi_regmaster_test.sv
module spi_regmaster_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sck_o, mosi_o, miso_i, ss_n_i = 1'b1, ss_release_o;

   int vectors = 0, miscomp = 0, cyc = 0;
   logic [7:0] slv_reg = 8'h00;
   logic       slv_out = 1'b0, slv_cap = 1'b0;
   logic       cpol_b = 1'b0, cpha_b = 1'b0;
   int         tog_cnt = 0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   spi_regmaster uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_i(ss_n_i),
      .ss_release_o(ss_release_o)
   );

   assign miso_i = cpha_b ? slv_out : slv_reg[7];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // behavioural slave and monitor: pops the byte the slave should have received
   always @(sck_o) begin
      tog_cnt++;
      if (sck_o != cpol_b) begin
         if (!cpha_b) slv_cap = mosi_o;
         else begin slv_out = slv_reg[7]; slv_reg = {slv_reg[6:0], 1'b0}; end
      end else begin
         if (!cpha_b) slv_reg = {slv_reg[6:0], slv_cap};
         else slv_reg[0] = mosi_o;
      end
      if (tog_cnt == 16 && exp_q.size() > 0) begin
         logic [7:0] e;
         e = exp_q.pop_front();
         chk("R3 slave byte", slv_reg, e);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         miscomp++;
         $display("FAIL R2: watchdog act=%0d exp<%0d", cyc, 150000);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   end

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic clear_flags();
      rd_reg(2'd1); rd_reg(2'd2);
   endtask

   task automatic set_ctl(input logic [7:0] ctl);
      wr_reg(2'd0, ctl);
      cpol_b = ctl[3]; cpha_b = ctl[2];
      repeat (2) @(negedge clk);
   endtask

   task automatic start_xfer(input logic [7:0] ctl, input logic [7:0] mtx,
                             input logic [7:0] stx, input bit push);
      set_ctl(ctl);
      clear_flags();
      @(negedge clk);
      slv_reg = stx; slv_out = 1'b0; tog_cnt = 0;
      if (push) exp_q.push_back(mtx);
      wr_reg(2'd2, mtx);
   endtask

   task automatic finish_xfer(input logic [7:0] stx, input string req);
      logic [7:0] s, d;
      int n;
      n = 0;
      s = 8'h00;
      while (n < 5000 && !s[7]) begin
         @(negedge clk); peek(2'd1, s); n++;
      end
      chk({req, " done flag"}, s[7], 1'b1);
      peek(2'd2, d);
      chk({req, " received byte"}, d, stx);
   endtask

   task automatic xfer(input logic [7:0] ctl, input logic [7:0] mtx,
                       input logic [7:0] stx, input string req);
      start_xfer(ctl, mtx, stx, 1'b1);
      finish_xfer(stx, req);
   endtask

   task automatic measure(input logic [7:0] ctl, input int exp_h, input string req);
      int n;
      start_xfer(ctl, 8'h6A, 8'h95, 1'b1);
      while (sck_o == cpol_b) @(negedge clk);
      n = 0;
      while (sck_o != cpol_b) begin n++; @(negedge clk); end
      chk(req, n, exp_h);
      finish_xfer(8'h95, req);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(2'd0, v); chk("R1 control", v, 8'h00);
      peek(2'd1, v); chk("R1 status", v, 8'h00);
      peek(2'd2, v); chk("R1 data", v, 8'h00);
      chk("R1 sck", sck_o, 1'b0);
      chk("R1 mosi", mosi_o, 1'b0);
      chk("R1 release", ss_release_o, 1'b0);

      // R2 R3 all four modes, several patterns
      xfer(8'h50, 8'hA5, 8'h3C, "R3 mode0");
      xfer(8'h54, 8'h96, 8'hE1, "R3 mode1");
      xfer(8'h58, 8'h0F, 8'hF0, "R3 mode2");
      xfer(8'h5C, 8'h81, 8'h7E, "R3 mode3");
      xfer(8'h51, 8'h00, 8'hFF, "R3 rate1");
      xfer(8'h5D, 8'hFF, 8'h00, "R3 mode3 rate1");
      chk("R2 sck idle at polarity", sck_o, 1'b1);
      chk("R2 eight pulses", tog_cnt, 16);

      // R5 half-period per rate code
      measure(8'h50, 1, "R5 code0");
      measure(8'h52, 4, "R5 code2");
      measure(8'hD2, 64, "R5 code6");
      measure(8'hD3, 64, "R5 code7");

      // R4 buffer holds old byte during transfer
      start_xfer(8'h53, 8'h11, 8'h22, 1'b1);
      repeat (20) @(negedge clk);
      peek(2'd2, v); chk("R4 buffer during transfer", v, 8'h95);
      finish_xfer(8'h22, "R4");

      // R6 collision, R7 clear sequence
      start_xfer(8'h53, 8'h5A, 8'hC3, 1'b1);
      repeat (10) @(negedge clk);
      wr_reg(2'd2, 8'hFF);
      peek(2'd1, v); chk("R6 collision flag", v[6], 1'b1);
      finish_xfer(8'hC3, "R6");
      rd_reg(2'd2);
      peek(2'd1, v); chk("R7 flags kept without status read", v, 8'hC0);
      rd_reg(2'd1); rd_reg(2'd2);
      peek(2'd1, v); chk("R7 flags cleared", v, 8'h00);

      // R8 mode fault mid-transfer
      start_xfer(8'h53, 8'h33, 8'h44, 1'b0);
      repeat (10) @(negedge clk);
      ss_n_i = 1'b0;
      repeat (6) @(negedge clk);
      peek(2'd1, v); chk("R8 fault flag", v[4], 1'b1);
      peek(2'd0, v); chk("R8 master cleared", v, 8'h43);
      chk("R8 sck idle", sck_o, 1'b0);
      repeat (200) @(negedge clk);
      peek(2'd1, v); chk("R8 no done", v[7], 1'b0);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);

      // R11 fault clear sequence
      wr_reg(2'd0, 8'h53);
      peek(2'd1, v); chk("R11 fault kept", v[4], 1'b1);
      rd_reg(2'd1);
      wr_reg(2'd0, 8'h53);
      peek(2'd1, v); chk("R11 fault cleared", v[4], 1'b0);

      // R9 select disabled
      set_ctl(8'h73);
      chk("R9 release out", ss_release_o, 1'b1);
      ss_n_i = 1'b0;
      xfer(8'h73, 8'h3C, 8'hA5, "R9");
      peek(2'd1, v); chk("R9 no fault", v[4], 1'b0);
      peek(2'd0, v); chk("R9 control kept", v, 8'h73);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);

      // R10 disable mid-transfer
      start_xfer(8'h5B, 8'h77, 8'h88, 1'b0);
      repeat (30) @(negedge clk);
      wr_reg(2'd0, 8'h1B);
      repeat (3) @(negedge clk);
      chk("R10 sck idle", sck_o, 1'b1);
      repeat (200) @(negedge clk);
      peek(2'd1, v); chk("R10 no done", v[7], 1'b0);
      peek(2'd2, v); chk("R10 buffer kept", v, 8'hA5);
      xfer(8'h5B, 8'h44, 8'hBB, "R10 restart");

      // R12 data write while disabled or not master
      set_ctl(8'h10);
      clear_flags();
      tog_cnt = 0;
      wr_reg(2'd2, 8'h99);
      repeat (100) @(negedge clk);
      chk("R12 no sck disabled", tog_cnt, 0);
      peek(2'd1, v); chk("R12 no done disabled", v[7], 1'b0);
      set_ctl(8'h40);
      tog_cnt = 0;
      wr_reg(2'd2, 8'h99);
      repeat (100) @(negedge clk);
      chk("R12 no sck slave", tog_cnt, 0);
      peek(2'd1, v); chk("R12 no done slave", v[7], 1'b0);
      chk("R3 scoreboard drained", exp_q.size(), 0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end
endmodule